// File: doc/BRIEF.md
# Configuration Handshake Status Sequencer

This block is the target-side sequencer for a serial device-configuration handshake. Two shared lines carry the handshake. Each is open-drain and wired-AND: any party may pull it low, and it reads high only when nobody does. One is a status line and the other is a done line. The block drives a pull-low enable for each line and reads back the resolved level. It moves through five phases: power-up hold, bitstream loading, done handoff, initialization and user mode. A fault phase is entered when loading fails.

The bitstream receiver supplies two single-cycle strobes, "all data received" and "data error". The board supplies an active-low restart request and an active-low chip enable. The restart request, the chip enable and both sensed line levels pass through a synchronizer of `SYNC_STAGES` flops before the state machine uses them. All durations are counted in clock cycles. `POR_CYCLES` sets the power-up hold and `INIT_CYCLES` sets initialization. The asynchronous reset stands for power-on.

An external low on the status line aborts the load when it arrives during loading, handoff or initialization. The same low has no effect once user mode is reached. An external low on the done line also has no effect in user mode. Only the restart request leaves user mode or the fault phase.

Top module: `cfg_handshake_seq`

## Requirements
- R1: While reset is asserted and right after it, the status pull (`status_pull_o`) and the done pull (`done_pull_o`) are both 1 and `user_mode_o` is 0. Whenever the status pull is 1, the done pull is also 1.
- R2: After reset is released, the status pull stays 1 for exactly `POR_CYCLES` clock cycles and then drops to 0.
- R3: A `rx_error_i` strobe while loading sets the status pull to 1 on the next clock edge. The block then remains in the fault phase with status pull 1, done pull 1 and user mode 0 until a restart is requested.
- R4: A status line sensed low during loading or initialization sends the block to the fault phase, with status pull 1. During loading, this check applies once `SYNC_STAGES` cycles have passed since the status pull was released.
- R5: In user mode, an external low on the status line has no effect: `user_mode_o` stays 1 and the status pull stays 0.
- R6: A sensed low on `reconfig_n_i` returns the block from any phase to power-up, with status pull 1, done pull 1 and user mode 0. This is the only exit from the fault phase. Power-up then restarts its `POR_CYCLES` count.
- R7: The done pull is 1 throughout loading. It drops to 0 on the clock edge that samples `rx_complete_i` high, provided that no error is present and chip enable is low.
- R8: If the done line rises as soon as it is released, `user_mode_o` rises exactly `SYNC_STAGES + 1 + INIT_CYCLES` cycles after the done pull drops.
- R9: In user mode, an external low on the done line has no effect: `user_mode_o` stays 1.
- R10: While `ce_n_i` is sensed high, `rx_complete_i` is ignored and the done pull stays 1. Also while it is sensed high, the handoff and initialization counts are frozen, so a high pulse of N cycles delays user mode by exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reconfig_n_i | input | 1 | Active-low restart request (asynchronous) |
| ce_n_i | input | 1 | Active-low chip enable (asynchronous) |
| status_line_i | input | 1 | Sensed level of the wired-AND status line |
| done_line_i | input | 1 | Sensed level of the wired-AND done line |
| rx_complete_i | input | 1 | Strobe: the whole bitstream has been received |
| rx_error_i | input | 1 | Strobe: the receiver found an error in the data |
| status_pull_o | output | 1 | 1 = pull the status line low |
| done_pull_o | output | 1 | 1 = pull the done line low |
| user_mode_o | output | 1 | 1 = device is in user mode |

## Verification
The hardest case to reach from the ports is a chip-enable pause that falls exactly on the boundary between the done handoff and initialization. That case is the only way to show that a frozen count resumes without losing or gaining a cycle. The bench models both lines as wired-AND nets from the design's own pulls and from an external pull. It raises chip enable on the very cycle it first sees the done pull drop and holds it high for ten cycles. It then checks that user mode arrives exactly ten cycles later than in an unpaused run. The bench also drives external lows on the status line at three points: in the middle of loading, in the middle of initialization and in user mode. This shows that the same line event is acted on in the first two phases and ignored in the third.

// File: rtl/cfg_hs_pkg.sv
package cfg_hs_pkg;

   typedef enum logic [2:0] {
      ST_POWERUP = 3'd0,
      ST_LOAD    = 3'd1,
      ST_HANDOFF = 3'd2,
      ST_INIT    = 3'd3,
      ST_USER    = 3'd4,
      ST_FAULT   = 3'd5
   } cfg_state_e;

   // bit positions inside the synchronized input vector
   localparam int unsigned SYNC_W       = 4;
   localparam int unsigned SB_RECONFIG  = 3;
   localparam int unsigned SB_CE        = 2;
   localparam int unsigned SB_STATUS    = 1;
   localparam int unsigned SB_DONE      = 0;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned       WIDTH   = 4,
   parameter int unsigned       STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
   parameter int unsigned          CNT_W   = 8,
   parameter logic [CNT_W-1:0]     RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= RST_VAL;
      else if (load)              cnt <= load_val;
      else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
   import cfg_hs_pkg::*;
#(
   parameter int unsigned      CNT_W    = 8,
   parameter logic [CNT_W-1:0] POR_LD   = '0,
   parameter logic [CNT_W-1:0] SETTLE_LD = '0,
   parameter logic [CNT_W-1:0] INIT_LD  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reconfig_s,
   input  logic             ce_n_s,
   input  logic             status_s,
   input  logic             done_s,
   input  logic             rx_complete,
   input  logic             rx_error,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             tmr_dec,
   output cfg_state_e       state
);

   cfg_state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_POWERUP;
      else        state <= nxt;
   end

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tmr_dec  = 1'b0;
      if (!reconfig_s) begin
         nxt      = ST_POWERUP;
         tmr_load = 1'b1;
         tmr_val  = POR_LD;
      end else begin
         unique case (state)
            ST_POWERUP: begin
               if (tmr_zero) begin
                  nxt      = ST_LOAD;
                  tmr_load = 1'b1;
                  tmr_val  = SETTLE_LD;
               end else begin
                  tmr_dec = 1'b1;
               end
            end
            ST_LOAD: begin
               tmr_dec = !tmr_zero;
               if (rx_error)
                  nxt = ST_FAULT;
               else if (tmr_zero && !status_s)
                  nxt = ST_FAULT;
               else if (tmr_zero && !ce_n_s && rx_complete)
                  nxt = ST_HANDOFF;
            end
            ST_HANDOFF: begin
               if (!status_s)
                  nxt = ST_FAULT;
               else if (!ce_n_s && done_s) begin
                  nxt      = ST_INIT;
                  tmr_load = 1'b1;
                  tmr_val  = INIT_LD;
               end
            end
            ST_INIT: begin
               if (!status_s)
                  nxt = ST_FAULT;
               else if (!ce_n_s) begin
                  if (tmr_zero) nxt = ST_USER;
                  else          tmr_dec = 1'b1;
               end
            end
            ST_USER:  nxt = ST_USER;
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/cfg_handshake_seq.sv
module cfg_handshake_seq
   import cfg_hs_pkg::*;
#(
   parameter int unsigned POR_CYCLES  = 20,
   parameter int unsigned INIT_CYCLES = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reconfig_n_i,
   input  logic ce_n_i,
   input  logic status_line_i,
   input  logic done_line_i,
   input  logic rx_complete_i,
   input  logic rx_error_i,
   output logic status_pull_o,
   output logic done_pull_o,
   output logic user_mode_o
);

   localparam int unsigned MAX_A = (POR_CYCLES > INIT_CYCLES) ? POR_CYCLES : INIT_CYCLES;
   localparam int unsigned MAX_T = (MAX_A > SYNC_STAGES) ? MAX_A : SYNC_STAGES;
   localparam int unsigned CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] POR_LD    = CNT_W'(POR_CYCLES - 1);
   localparam logic [CNT_W-1:0] INIT_LD   = CNT_W'(INIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SYNC_STAGES);
   localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(4'b1100);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (POR_CYCLES <= SYNC_STAGES + 1) begin : g_bad_por
      $error("POR_CYCLES must exceed SYNC_STAGES + 1");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic [SYNC_W-1:0] raw_vec, sync_vec;
   logic              reconfig_s, ce_n_s, status_s, done_s;
   logic              tmr_load, tmr_dec, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   cfg_state_e        state;

   assign raw_vec = {reconfig_n_i, ce_n_i, status_line_i, done_line_i};

   cfg_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   assign reconfig_s = sync_vec[SB_RECONFIG];
   assign ce_n_s     = sync_vec[SB_CE];
   assign status_s   = sync_vec[SB_STATUS];
   assign done_s     = sync_vec[SB_DONE];

   cfg_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (POR_LD)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .zero     (tmr_zero)
   );

   cfg_fsm #(
      .CNT_W     (CNT_W),
      .POR_LD    (POR_LD),
      .SETTLE_LD (SETTLE_LD),
      .INIT_LD   (INIT_LD)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .reconfig_s  (reconfig_s),
      .ce_n_s      (ce_n_s),
      .status_s    (status_s),
      .done_s      (done_s),
      .rx_complete (rx_complete_i),
      .rx_error    (rx_error_i),
      .tmr_zero    (tmr_zero),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .tmr_dec     (tmr_dec),
      .state       (state)
   );

   assign status_pull_o = (state == ST_POWERUP) || (state == ST_FAULT);
   assign done_pull_o   = (state == ST_POWERUP) || (state == ST_LOAD) || (state == ST_FAULT);
   assign user_mode_o   = (state == ST_USER);

endmodule

// File: rtl/cfg_handshake_seq_chk.sv
module cfg_handshake_seq_chk
   import cfg_hs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reconfig_s,
   input logic       ce_n_s,
   input logic       rx_complete_i,
   input logic       rx_error_i,
   input logic       status_pull_o,
   input logic       done_pull_o,
   input logic       user_mode_o,
   input cfg_state_e state
);

   assert_done_with_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status_pull_o |-> done_pull_o);

   assert_error_pulls_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && rx_error_i && reconfig_s) |=> status_pull_o);

   assert_user_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode_o && reconfig_s) |=> user_mode_o);

   assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAULT && reconfig_s) |=> (status_pull_o && !user_mode_o));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reconfig_s |=> (state == ST_POWERUP));

   assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_pull_o) |-> $past(rx_complete_i));

   assert_user_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode_o) |-> $past(state == ST_INIT));

   assert_ce_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pull_o && !status_pull_o && ce_n_s) |=> done_pull_o);

endmodule

bind cfg_handshake_seq cfg_handshake_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reconfig_s    (reconfig_s),
   .ce_n_s        (ce_n_s),
   .rx_complete_i (rx_complete_i),
   .rx_error_i    (rx_error_i),
   .status_pull_o (status_pull_o),
   .done_pull_o   (done_pull_o),
   .user_mode_o   (user_mode_o),
   .state         (state)
);

// File: tb/cfg_handshake_seq_tb.sv
`timescale 1ns/1ps
module cfg_handshake_seq_tb;

   localparam int POR   = 20;
   localparam int INIT  = 12;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reconfig_n = 1'b1, ce_n = 1'b0;
   logic ext_status_low = 1'b0, ext_done_low = 1'b0;
   logic rx_complete = 1'b0, rx_error = 1'b0;
   logic status_pull, done_pull, user_mode;
   logic status_line, done_line;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // expected output tuples {status_pull, done_pull, user_mode}
   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   assign status_line = ~(status_pull | ext_status_low);
   assign done_line   = ~(done_pull | ext_done_low);

   cfg_handshake_seq #(.POR_CYCLES(POR), .INIT_CYCLES(INIT), .SYNC_STAGES(SYNC)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .reconfig_n_i (reconfig_n), .ce_n_i (ce_n),
      .status_line_i (status_line), .done_line_i (done_line),
      .rx_complete_i (rx_complete), .rx_error_i (rx_error),
      .status_pull_o (status_pull), .done_pull_o (done_pull), .user_mode_o (user_mode)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_next(input logic [2:0] v, input string req);
      exp_q.push_back(v);
      tag_q.push_back(req);
   endtask

   // monitor: every change of the output tuple must match the next expected item
   initial begin : monitor
      logic [2:0] prev;
      logic [2:0] cur;
      prev = 3'b110;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         cur = {status_pull, done_pull, user_mode};
         if (cur != prev) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "unexpected_change", int'(cur), int'(prev));
            end else begin
               logic [2:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(cur == e, t, int'(cur), int'(e));
            end
            prev = cur;
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_status_release(input string req);
      int n = 0;
      while (status_pull && n < 500) begin
         @(negedge clk);
         n++;
      end
      check(!status_pull, req, int'(status_pull), 0);
   endtask

   task automatic restart(input string req);
      expect_next(3'b010, req);
      reconfig_n = 1'b0;
      cycles(4);
      reconfig_n = 1'b1;
      wait_status_release(req);
      cycles(6);
   endtask

   task automatic pulse_complete();
      rx_complete = 1'b1;
      @(negedge clk);
      rx_complete = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      int cnt;
      cycles(3);
      // R1: reset state
      check({status_pull, done_pull, user_mode} == 3'b110, "R1 reset tuple",
            int'({status_pull, done_pull, user_mode}), 6);
      // R2: power-up hold length
      expect_next(3'b010, "R2 status release");
      rst_n = 1'b1;
      cnt = 0;
      while (status_pull && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == POR, "R2 power-up cycles", cnt, POR);
      check(done_pull == 1'b1, "R7 done held during load", int'(done_pull), 1);
      cycles(6);

      // R10: completion ignored with chip enable high
      ce_n = 1'b1;
      cycles(5);
      pulse_complete();
      cycles(5);
      check(done_pull == 1'b1, "R10 completion ignored", int'(done_pull), 1);
      ce_n = 1'b0;
      cycles(5);

      // R7, R8: normal load to user mode
      expect_next(3'b000, "R7 done release");
      expect_next(3'b001, "R8 user entry");
      rx_complete = 1'b1;
      @(negedge clk);
      rx_complete = 1'b0;
      check(done_pull == 1'b0, "R7 done drops after strobe edge", int'(done_pull), 0);
      cnt = 0;
      while (!user_mode && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == INIT + SYNC + 1, "R8 init latency", cnt, INIT + SYNC + 1);

      // R9: done line low in user mode ignored
      ext_done_low = 1'b1;
      cycles(10);
      check(user_mode == 1'b1, "R9 user kept with done low", int'(user_mode), 1);
      ext_done_low = 1'b0;
      // R5: status line low in user mode ignored
      ext_status_low = 1'b1;
      cycles(10);
      check(user_mode == 1'b1 && status_pull == 1'b0, "R5 user kept with status low",
            int'({status_pull, user_mode}), 1);
      ext_status_low = 1'b0;
      cycles(5);

      // R6: restart from user mode
      expect_next(3'b110, "R6 restart from user");
      restart("R6 power-up after restart");

      // R3: data error during load
      expect_next(3'b110, "R3 error pull");
      rx_error = 1'b1;
      @(negedge clk);
      rx_error = 1'b0;
      check(status_pull == 1'b1, "R3 status pulled next edge", int'(status_pull), 1);
      cycles(30);
      check({status_pull, done_pull, user_mode} == 3'b110, "R3 fault held",
            int'({status_pull, done_pull, user_mode}), 6);
      restart("R6 exit from fault");

      // R4: external status low during load
      expect_next(3'b110, "R4 fault on status low in load");
      ext_status_low = 1'b1;
      cycles(8);
      ext_status_low = 1'b0;
      cycles(5);
      check(status_pull == 1'b1, "R4 load abort", int'(status_pull), 1);
      restart("R6 exit after R4 load");

      // R4: external status low during initialization
      expect_next(3'b000, "R7 done release 2");
      expect_next(3'b110, "R4 fault on status low in init");
      pulse_complete();
      cycles(5);
      ext_status_low = 1'b1;
      cycles(8);
      ext_status_low = 1'b0;
      check(user_mode == 1'b0 && status_pull == 1'b1, "R4 init abort",
            int'({status_pull, user_mode}), 2);
      restart("R6 exit after R4 init");

      // R10: chip-enable pause at handoff/init boundary
      expect_next(3'b000, "R7 done release 3");
      expect_next(3'b001, "R10 user after pause");
      rx_complete = 1'b1;
      @(negedge clk);
      rx_complete = 1'b0;
      cnt = 0;
      ce_n = 1'b1;
      while (!user_mode && cnt < 1000) begin
         cnt++;
         if (cnt == 11) ce_n = 1'b0;
         @(negedge clk);
      end
      check(cnt == INIT + SYNC + 11, "R10 paused init latency", cnt, INIT + SYNC + 11);
      cycles(5);

      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule